// File: doc/BRIEF.md
# Dual Sticky PLL Unlock Detector

This block watches two independent phase-locked loops and keeps one unlock flag for each. It measures the width of every phase error pulse, where an error pulse is the up output or the down output of that loop's phase comparator being high. When a pulse stays high for longer than a programmable number of system clocks, the block raises that loop's flag. The flag stays set after the loop settles again. Only a completed serial transfer by the host clears it, and a read and a write count the same. The host therefore never misses a short loss of lock that happened between two polls.

A retune strobe marks a divisor change. It sets the flag at once, so the host cannot read a stale "locked" result. After a retune, a transfer can clear the flag only once two reference periods have passed. This matches the settling time a loop needs before a lock check means anything. Each flag can also drive an open-drain style pin. A control bit per loop can force that pin low whatever the flag holds.

Top module: `pll_unlock_watch`

## Requirements
- R1: After a synchronous reset, both flags read 0 and both pin pull-down outputs read 0 (released).
- R2: A flag is set when that loop's up or down input stays high for more than L consecutive clocks, where L is the effective limit. A pulse of exactly L clocks leaves the flag unchanged.
- R3: The effective limit L equals `err_limit`, except that an `err_limit` of 0 selects the default of 8 clocks.
- R4: Once set, a flag stays set for as long as no transfer strobe arrives, even after the error pulses stop.
- R5: A one-cycle `xfer_done` strobe clears every flag that is set and not in its settling window. The flag reads 0 from the next cycle on.
- R6: When a set condition and a transfer strobe occur in the same cycle, the flag is set or stays set.
- R7: A one-cycle `retune` strobe sets that loop's flag on the next cycle.
- R8: After a retune, `xfer_done` has no effect on that loop's flag until two `ref_tick` strobes have been seen. A transfer after the second tick clears the flag.
- R9: `pin_pull_low[i]` is 1 (drive low) exactly when flag i is set or `force_low[i]` is 1. Otherwise it is 0 (released).
- R10: The two loops are independent: events on one loop never change the other loop's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_up | input | 2 | Phase comparator up pulse, one bit per loop |
| err_dn | input | 2 | Phase comparator down pulse, one bit per loop |
| err_limit | input | 8 | Pulse width limit in clocks; 0 selects 8 |
| retune | input | 2 | Divisor-change strobe, one bit per loop |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| xfer_done | input | 1 | One-cycle strobe at the end of any serial transfer |
| force_low | input | 2 | Per-loop control: 1 forces the pin low |
| unlock_flag | output | 2 | Sticky unlock flags for the status word |
| pin_pull_low | output | 2 | 1 drives the open-drain pin low, 0 releases it |

## Verification
The assertions check on every cycle that a flag rises only after an over-limit pulse or a retune, and that it falls only after a transfer outside the settling window. They also check that a flag stays set throughout that window and that the pulse-width counter restarts when the error input goes quiet. The exact threshold edge (a pulse of L clocks against one of L+1), the substitution of the default limit and the same-cycle race between set and clear need the bench's directed pulses. So do the two-tick settling rule, the forced-low pin control and the isolation between the loops.

// File: rtl/pll_unlock_pkg.sv
// Package: shared constants for the dual unlock detector.
// Assumes: all users share one limit width and one settling length.
package pll_unlock_pkg;
    localparam int unsigned LIMIT_W       = 8;
    localparam int unsigned DEFAULT_LIMIT = 8;
    localparam int unsigned SETTLE_TICKS  = 2;
    localparam int unsigned SETTLE_W      = $clog2(SETTLE_TICKS + 1);
    typedef logic [LIMIT_W-1:0]  limit_t;
    typedef logic [SETTLE_W-1:0] settle_t;
endpackage

// File: rtl/pulse_width_meter.sv
// Module: pulse_width_meter
// Counts how many consecutive clocks a loop's error pulse (up or down) has
// been high, and raises 'over' in any cycle where the pulse is high and has
// already lasted at least 'limit' clocks. In that case the current cycle is
// beyond the limit.
// Assumes: 'limit' is stable while a pulse is being measured.
module pulse_width_meter
    import pll_unlock_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   up,
    input  logic   dn,
    input  limit_t limit,
    output logic   over
);
    localparam limit_t CNT_MAX = '1;

    logic   err;
    limit_t run_len;

    assign err  = up | dn;
    assign over = err && (run_len >= limit);

    // Run-length counter of the error pulse, saturating, restarted when quiet.
    always_ff @(posedge clk) begin
        if (!rst_n)                run_len <= '0;
        else if (!err)             run_len <= '0;
        else if (run_len != CNT_MAX) run_len <= run_len + 1'b1;
    end

    // A quiet error input restarts the count (R2).
    assert_run_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !err |=> run_len == '0);
    // The counter never moves while it is saturated (R2).
    assert_run_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err && run_len == CNT_MAX) |=> run_len == CNT_MAX);
endmodule

// File: rtl/sticky_unlock_latch.sv
// Module: sticky_unlock_latch
// Holds one loop's unlock flag. The flag is set by an over-limit pulse or a
// retune and cleared only by a transfer strobe. After a retune, clearing is
// blocked until SETTLE_TICKS reference strobes have passed. Set wins over clear.
// Assumes: all strobes are single-cycle and synchronous to clk.
module sticky_unlock_latch
    import pll_unlock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic over,
    input  logic retune,
    input  logic ref_tick,
    input  logic xfer_done,
    output logic flag
);
    settle_t settle;
    logic    set_req;
    logic    clr_req;

    assign set_req = over | retune;
    assign clr_req = xfer_done && (settle == '0);

    // Settling window: reload on retune, count down on reference strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)                         settle <= '0;
        else if (retune)                    settle <= settle_t'(SETTLE_TICKS);
        else if (ref_tick && settle != '0)  settle <= settle - 1'b1;
    end

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // An over-limit pulse always leaves the flag set (R2, R6).
    assert_over_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        over |=> flag);
    // A retune sets the flag on the next cycle (R7).
    assert_retune_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retune |=> flag);
    // The flag can only fall after a transfer outside the window (R4, R5).
    assert_fall_needs_xfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> ($past(xfer_done) && $past(settle) == '0));
    // The flag stays set throughout the settling window (R8).
    assert_held_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (settle != '0) |-> flag);
endmodule

// File: rtl/pll_unlock_watch.sv
// Module: pll_unlock_watch (top)
// Dual sticky PLL unlock detector. Each loop gets a pulse-width meter and a
// sticky latch, and its open-drain pin pull-down is the flag ORed with the
// forced-low control bit. The limit of zero is replaced by the default limit.
// Assumes: one shared clock domain. The phase comparators and the serial
// interface sit outside and deliver synchronous pulses and strobes.
module pll_unlock_watch
    import pll_unlock_pkg::*;
#(
    parameter int unsigned NUM_PLL = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PLL-1:0] err_up,
    input  logic [NUM_PLL-1:0] err_dn,
    input  logic [LIMIT_W-1:0] err_limit,
    input  logic [NUM_PLL-1:0] retune,
    input  logic               ref_tick,
    input  logic               xfer_done,
    input  logic [NUM_PLL-1:0] force_low,
    output logic [NUM_PLL-1:0] unlock_flag,
    output logic [NUM_PLL-1:0] pin_pull_low
);
    limit_t eff_limit;

    // Substitute the default limit when the programmed limit is zero (R3).
    always_comb begin
        eff_limit = (err_limit == '0) ? limit_t'(DEFAULT_LIMIT) : err_limit;
    end

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        logic over;

        pulse_width_meter u_meter (
            .clk   (clk),
            .rst_n (rst_n),
            .up    (err_up[g]),
            .dn    (err_dn[g]),
            .limit (eff_limit),
            .over  (over)
        );

        sticky_unlock_latch u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .over      (over),
            .retune    (retune[g]),
            .ref_tick  (ref_tick),
            .xfer_done (xfer_done),
            .flag      (unlock_flag[g])
        );

        assign pin_pull_low[g] = unlock_flag[g] | force_low[g];

        // A released pin with no forcing implies a clear flag one cycle on,
        // unless a set arrived (R9).
        assert_pin_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!pin_pull_low[g] && !over && !retune[g]) |=> !unlock_flag[g]);
    end
endmodule

// File: tb/tb_pll_unlock_watch.sv
module tb_pll_unlock_watch;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] err_up, err_dn, retune, force_low;
    logic [7:0] err_limit;
    logic       ref_tick, xfer_done;
    logic [1:0] unlock_flag, pin_pull_low;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;  // 250 MHz

    pll_unlock_watch dut (
        .clk(clk), .rst_n(rst_n), .err_up(err_up), .err_dn(err_dn),
        .err_limit(err_limit), .retune(retune), .ref_tick(ref_tick),
        .xfer_done(xfer_done), .force_low(force_low),
        .unlock_flag(unlock_flag), .pin_pull_low(pin_pull_low)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Error pulse of len clocks on loop idx, up or down.
    task automatic pulse(input int idx, input bit use_up, input int len);
        @(negedge clk);
        if (use_up) err_up[idx] = 1'b1; else err_dn[idx] = 1'b1;
        cyc(len);
        err_up = '0; err_dn = '0;
        cyc(1);
    endtask

    task automatic xfer();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 flags", unlock_flag, 2'b00);
        chk("R1 pins", pin_pull_low, 2'b00);
    endtask

    task automatic t_threshold();
        err_limit = 8'd5;
        pulse(0, 1'b1, 5);
        chk("R2 exact limit", unlock_flag, 2'b00);
        pulse(0, 1'b0, 6);
        chk("R2 over limit dn", unlock_flag, 2'b01);
        chk("R10 other loop", unlock_flag[1], 1'b0);
    endtask

    task automatic t_sticky();
        cyc(20);
        chk("R4 sticky", unlock_flag, 2'b01);
        xfer();
        chk("R5 clear", unlock_flag, 2'b00);
        pulse(1, 1'b1, 6);
        chk("R10 loop1 alone", unlock_flag, 2'b10);
        xfer();
        chk("R5 clear loop1", unlock_flag, 2'b00);
    endtask

    task automatic t_default();
        err_limit = 8'd0;
        pulse(1, 1'b1, 8);
        chk("R3 default 8 no set", unlock_flag, 2'b00);
        pulse(1, 1'b0, 9);
        chk("R3 default 9 sets", unlock_flag, 2'b10);
        xfer();
        chk("R5 clear after R3", unlock_flag, 2'b00);
    endtask

    task automatic t_race();
        // limit 8: detect on the 9th high edge, transfer on that same edge
        @(negedge clk); err_up[0] = 1'b1;
        cyc(8);
        xfer_done = 1'b1;
        @(negedge clk); err_up = '0; xfer_done = 1'b0;
        cyc(1);
        chk("R6 set wins", unlock_flag, 2'b01);
        xfer();
        chk("R6 later clear", unlock_flag, 2'b00);
    endtask

    task automatic t_retune();
        @(negedge clk); retune[1] = 1'b1;
        @(negedge clk); retune = '0;
        chk("R7 retune sets", unlock_flag, 2'b10);
        xfer();
        chk("R8 blocked 0 ticks", unlock_flag, 2'b10);
        tick();
        xfer();
        chk("R8 blocked 1 tick", unlock_flag, 2'b10);
        tick();
        xfer();
        chk("R8 clear after 2 ticks", unlock_flag, 2'b00);
    endtask

    task automatic t_pin();
        @(negedge clk); force_low = 2'b01;
        cyc(1);
        chk("R9 forced", pin_pull_low, 2'b01);
        force_low = 2'b00;
        pulse(1, 1'b1, 9);
        chk("R9 flag drives", pin_pull_low, 2'b10);
        xfer();
        chk("R9 released", pin_pull_low, 2'b00);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; err_up = '0; err_dn = '0; retune = '0; force_low = '0;
        err_limit = 8'd0; ref_tick = 1'b0; xfer_done = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_threshold();
        t_sticky();
        t_default();
        t_race();
        t_retune();
        t_pin();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule